// File: doc/BRIEF.md
# Atomic GPIO Port Register Bank

This block holds the output values, pin directions and write masks of a set of GPIO ports, two 32-bit ports by default. It is reached through a simple synchronous register bus. Software can change single output or direction bits without reading the register first. It does this by writing a word of ones to a strobe register: one clears output bits, one inverts them, one turns pins into outputs and one turns them into inputs. A zero bit in such a word leaves its pin alone.

Beside the strobe registers each port has a plain data register, a mask register, a masked-data register and a direction register. The masked-data register changes only the bits whose mask bit is 0. The clear and invert strobes ignore the mask. Each register kind has a fixed base address, and the copy for port p sits at base + 4·p. Only the lowest 29 direction bits exist. The block drives an output-value vector and an output-enable vector to the pads, one slice per port.

The design has no control state machine. Each port is a group of registers whose next value is chosen by the decoded register kind. Each write completes in one cycle and each read answers one cycle later.

Top module: `gpab_bank`

## Requirements
- R1: After reset every output value, direction bit and mask bit is 0, so pad_out, pad_oe and bus_rdata are all 0.
- R2: A write to the data register (0x2100 + 4·p) replaces port p's output bits. A read of it returns those bits.
- R3: A write to the masked-data register (0x2180 + 4·p) updates only the output bits whose mask bit (register 0x2080 + 4·p) is 0. A read of the masked-data register returns the output bits with the masked bits forced to 0.
- R4: Writing to the clear strobe (0x2280 + 4·p) drives every output bit that has a 1 in the written word low. Bits written with 0 keep their value, and the mask has no effect.
- R5: Writing to the invert strobe (0x2300 + 4·p) inverts every output bit that has a 1 in the written word, whatever the mask holds.
- R6: Writing to the direction-set strobe (0x2380 + 4·p) makes each pin with a 1 in the written word an output. Its bit in pad_oe goes to 1.
- R7: Writing to the direction-clear strobe (0x2400 + 4·p) makes each pin with a 1 in the written word an input. Its bit in pad_oe goes to 0.
- R8: Only direction bits 28:0 exist. Bits 31:29 read as 0, drive pad_oe low and ignore every write. The direction register at 0x2000 + 4·p can be read and written directly.
- R9: The four strobe registers read as 0. A cycle without a decoded write changes no stored state.
- R10: The ports are independent. A write to port p's register leaves every other port's outputs and directions unchanged.
- R11: A misaligned address, or an address that matches no register, changes nothing on a write and reads as 0.
- R12: bus_rdata shows the addressed value in the cycle after bus_rd is high, and is 0 after any cycle in which bus_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 14 | Byte address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, one cycle after bus_rd |
| pad_out | output | 64 | Output values, port p in bits 32·p+31:32·p |
| pad_oe | output | 64 | Output enables, port p in bits 32·p+31:32·p |

## Verification
The update logic is exercised with the following patterns:
- Alternating nibble patterns show whether clear and invert act only on the bits written as 1.
- A half-word mask followed by a masked write, an invert and a clear shows that only the masked-data path honours the mask.
- All-ones direction strobes expose the three reserved direction bits.
- Writes to port 1 while port 0 holds known data show that the ports are kept apart.
- Misaligned and unmapped addresses show that the decoder rejects them.

// File: rtl/gpab_pkg.sv
package gpab_pkg;

    typedef enum logic [2:0] {
        K_DIR   = 3'd0,
        K_MASK  = 3'd1,
        K_DATA  = 3'd2,
        K_MDATA = 3'd3,
        K_CLR   = 3'd4,
        K_TGL   = 3'd5,
        K_DSET  = 3'd6,
        K_DCLR  = 3'd7
    } kind_e;

    localparam int NKIND = 8;
    localparam int STRIDE = 4;

    // Base byte offset of each register kind; port p adds STRIDE*p.
    function automatic int kind_base(input int k);
        case (k)
            0:       return 32'h2000;
            1:       return 32'h2080;
            2:       return 32'h2100;
            3:       return 32'h2180;
            4:       return 32'h2280;
            5:       return 32'h2300;
            6:       return 32'h2380;
            default: return 32'h2400;
        endcase
    endfunction

endpackage

// File: rtl/gpab_decode.sv
module gpab_decode
    import gpab_pkg::*;
#(
    parameter int NPORTS = 2,
    parameter int ADDR_W = 14,
    localparam int PW = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output kind_e             kind,
    output logic [PW-1:0]     port
);

    always_comb begin
        int a;
        hit  = 1'b0;
        kind = K_DIR;
        port = '0;
        a    = int'(addr);
        for (int k = 0; k < NKIND; k++) begin
            int b;
            b = kind_base(k);
            if (addr[1:0] == 2'b00 && a >= b && a < b + NPORTS * STRIDE) begin
                hit  = 1'b1;
                kind = kind_e'(3'(k));
                port = PW'((a - b) / STRIDE);
            end
        end
    end

endmodule

// File: rtl/gpab_port.sv
module gpab_port
    import gpab_pkg::*;
#(
    parameter int WIDTH    = 32,
    parameter int DIR_BITS = 29
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  kind_e               kind,
    input  logic [WIDTH-1:0]    wdata,
    output logic [WIDTH-1:0]    out_q,
    output logic [DIR_BITS-1:0] dir_q,
    output logic [WIDTH-1:0]    mask_q
);

    logic [WIDTH-1:0]    out_n;
    logic [WIDTH-1:0]    mask_n;
    logic [DIR_BITS-1:0] dir_n;
    logic [DIR_BITS-1:0] wdir;

    assign wdir = wdata[DIR_BITS-1:0];

    always_comb begin
        out_n  = out_q;
        dir_n  = dir_q;
        mask_n = mask_q;
        if (we) begin
            unique case (kind)
                K_DIR:   dir_n  = wdir;
                K_MASK:  mask_n = wdata;
                K_DATA:  out_n  = wdata;
                K_MDATA: out_n  = (out_q & mask_q) | (wdata & ~mask_q);
                K_CLR:   out_n  = out_q & ~wdata;
                K_TGL:   out_n  = out_q ^ wdata;
                K_DSET:  dir_n  = dir_q | wdir;
                K_DCLR:  dir_n  = dir_q & ~wdir;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q  <= '0;
            dir_q  <= '0;
            mask_q <= '0;
        end else begin
            out_q  <= out_n;
            dir_q  <= dir_n;
            mask_q <= mask_n;
        end
    end

    // R3: masked bits survive a masked-data write
    p_mdata_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (we && kind == K_MDATA) |=> (((out_q ^ $past(out_q)) & $past(mask_q)) == '0));

    // R4: every bit written as 1 to the clear strobe is low afterwards
    p_clr_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (we && kind == K_CLR) |=> ((out_q & $past(wdata)) == '0));

    // R5: bits written as 0 to the invert strobe keep their value
    p_tgl_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (we && kind == K_TGL) |=> (((out_q ^ $past(out_q)) & ~$past(wdata)) == '0));

    // R6: direction-set leaves the written ones set
    p_dset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (we && kind == K_DSET) |=> ((dir_q & $past(wdir)) == $past(wdir)));

    // R7: direction-clear leaves the written ones cleared
    p_dclr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (we && kind == K_DCLR) |=> ((dir_q & $past(wdir)) == '0));

    // R9: no decoded write, no state change
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> ($stable(out_q) && $stable(dir_q) && $stable(mask_q)));

endmodule

// File: rtl/gpab_rdmux.sv
module gpab_rdmux
    import gpab_pkg::*;
#(
    parameter int NPORTS   = 2,
    parameter int WIDTH    = 32,
    parameter int DIR_BITS = 29,
    localparam int PW = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             rd,
    input  logic                             hit,
    input  kind_e                            kind,
    input  logic [PW-1:0]                    port,
    input  logic [NPORTS-1:0][WIDTH-1:0]     outs,
    input  logic [NPORTS-1:0][DIR_BITS-1:0]  dirs,
    input  logic [NPORTS-1:0][WIDTH-1:0]     masks,
    output logic [WIDTH-1:0]                 rdata
);

    logic [WIDTH-1:0] val;

    always_comb begin
        val = '0;
        if (hit) begin
            unique case (kind)
                K_DIR:   val = WIDTH'(dirs[port]);
                K_MASK:  val = masks[port];
                K_DATA:  val = outs[port];
                K_MDATA: val = outs[port] & ~masks[port];
                default: val = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= rd ? val : '0;
    end

endmodule

// File: rtl/gpab_bank.sv
module gpab_bank
    import gpab_pkg::*;
#(
    parameter int NPORTS   = 2,
    parameter int WIDTH    = 32,
    parameter int DIR_BITS = 29,
    parameter int ADDR_W   = 14
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic                    bus_wr,
    input  logic [WIDTH-1:0]        bus_wdata,
    input  logic                    bus_rd,
    output logic [WIDTH-1:0]        bus_rdata,
    output logic [NPORTS*WIDTH-1:0] pad_out,
    output logic [NPORTS*WIDTH-1:0] pad_oe
);

    localparam int PW = (NPORTS > 1) ? $clog2(NPORTS) : 1;

    logic                            hit;
    kind_e                           kind;
    logic [PW-1:0]                   port;
    logic [NPORTS-1:0][WIDTH-1:0]    outs;
    logic [NPORTS-1:0][WIDTH-1:0]    masks;
    logic [NPORTS-1:0][DIR_BITS-1:0] dirs;

    gpab_decode #(.NPORTS(NPORTS), .ADDR_W(ADDR_W)) i_dec (
        .addr (bus_addr),
        .hit  (hit),
        .kind (kind),
        .port (port)
    );

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        logic we;
        assign we = bus_wr && hit && (port == PW'(p));

        gpab_port #(.WIDTH(WIDTH), .DIR_BITS(DIR_BITS)) i_port (
            .clk    (clk),
            .rst_n  (rst_n),
            .we     (we),
            .kind   (kind),
            .wdata  (bus_wdata),
            .out_q  (outs[p]),
            .dir_q  (dirs[p]),
            .mask_q (masks[p])
        );

        assign pad_out[p*WIDTH +: WIDTH] = outs[p];
        assign pad_oe[p*WIDTH +: WIDTH]  = WIDTH'(dirs[p]);
    end

    gpab_rdmux #(.NPORTS(NPORTS), .WIDTH(WIDTH), .DIR_BITS(DIR_BITS)) i_rd (
        .clk   (clk),
        .rst_n (rst_n),
        .rd    (bus_rd),
        .hit   (hit),
        .kind  (kind),
        .port  (port),
        .outs  (outs),
        .dirs  (dirs),
        .masks (masks),
        .rdata (bus_rdata)
    );

    // R12: no read request, read data returns to zero
    p_rd_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == '0));

    // R11: a misaligned write leaves all pads unchanged
    p_misalign_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[1:0] != 2'b00) |=> ($stable(pad_out) && $stable(pad_oe)));

    // R9: reading a strobe register always yields zero
    p_strobe_rd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && hit && kind inside {K_CLR, K_TGL, K_DSET, K_DCLR}) |=> (bus_rdata == '0));

endmodule

// File: tb/test_gpab_bank.sv
module test_gpab_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [63:0] pad_out;
    logic [63:0] pad_oe;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    gpab_bank i_gpab_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe)
    );

    typedef struct packed {
        logic        wr;
        logic [13:0] addr;
        logic [31:0] data;   // write data, or expected read data
        logic [7:0]  req;
        logic [31:0] o0;
        logic [31:0] o1;
        logic [31:0] e0;
        logic [31:0] e1;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 14'h2100, 32'hF0F0F0F0, 8'd2,  32'hF0F0F0F0, 32'h00000000, 32'h00000000, 32'h00000000}, // R2
        '{1'b1, 14'h2104, 32'h12345678, 8'd10, 32'hF0F0F0F0, 32'h12345678, 32'h00000000, 32'h00000000}, // R10
        '{1'b0, 14'h2100, 32'hF0F0F0F0, 8'd2,  32'hF0F0F0F0, 32'h12345678, 32'h00000000, 32'h00000000}, // R2
        '{1'b1, 14'h2280, 32'h000000FF, 8'd4,  32'hF0F0F000, 32'h12345678, 32'h00000000, 32'h00000000}, // R4
        '{1'b1, 14'h2080, 32'hFFFF0000, 8'd3,  32'hF0F0F000, 32'h12345678, 32'h00000000, 32'h00000000}, // R3
        '{1'b1, 14'h2180, 32'h0F0F0F0F, 8'd3,  32'hF0F00F0F, 32'h12345678, 32'h00000000, 32'h00000000}, // R3
        '{1'b0, 14'h2180, 32'h00000F0F, 8'd3,  32'hF0F00F0F, 32'h12345678, 32'h00000000, 32'h00000000}, // R3
        '{1'b1, 14'h2300, 32'hFFFFFFFF, 8'd5,  32'h0F0FF0F0, 32'h12345678, 32'h00000000, 32'h00000000}, // R5
        '{1'b1, 14'h2280, 32'hFF000000, 8'd4,  32'h000FF0F0, 32'h12345678, 32'h00000000, 32'h00000000}, // R4
        '{1'b1, 14'h2380, 32'hFFFFFFFF, 8'd6,  32'h000FF0F0, 32'h12345678, 32'h1FFFFFFF, 32'h00000000}, // R6 R8
        '{1'b1, 14'h2400, 32'h0000FFFF, 8'd7,  32'h000FF0F0, 32'h12345678, 32'h1FFF0000, 32'h00000000}, // R7
        '{1'b1, 14'h2384, 32'h00000011, 8'd10, 32'h000FF0F0, 32'h12345678, 32'h1FFF0000, 32'h00000011}, // R6 R10
        '{1'b0, 14'h2000, 32'h1FFF0000, 8'd8,  32'h000FF0F0, 32'h12345678, 32'h1FFF0000, 32'h00000011}, // R8
        '{1'b0, 14'h2300, 32'h00000000, 8'd9,  32'h000FF0F0, 32'h12345678, 32'h1FFF0000, 32'h00000011}, // R9
        '{1'b1, 14'h2000, 32'hE00000AA, 8'd8,  32'h000FF0F0, 32'h12345678, 32'h000000AA, 32'h00000011}, // R8
        '{1'b1, 14'h2302, 32'hFFFFFFFF, 8'd11, 32'h000FF0F0, 32'h12345678, 32'h000000AA, 32'h00000011}, // R11
        '{1'b0, 14'h2500, 32'h00000000, 8'd11, 32'h000FF0F0, 32'h12345678, 32'h000000AA, 32'h00000011}, // R11
        '{1'b1, 14'h2304, 32'h0000000F, 8'd5,  32'h000FF0F0, 32'h12345677, 32'h000000AA, 32'h00000011}  // R5
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_wr(input logic [13:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic do_rd(input logic [13:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        bus_rd   = 1'b1;
        @(negedge clk);
        bus_rd   = 1'b0;
        d        = bus_rdata;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #500000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] rv;
        string tag;

        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 pad_out at reset", pad_out, 64'h0);
        check("R1 pad_oe at reset", pad_oe, 64'h0);
        check("R1 rdata at reset", {32'h0, bus_rdata}, 64'h0);
        rst_n = 1'b1;
        do_rd(14'h2084, rv);
        check("R1 mask after reset", {32'h0, rv}, 64'h0);

        for (int i = 0; i < NV; i++) begin
            tag = $sformatf("R%0d step %0d", VEC[i].req, i);
            if (VEC[i].wr) begin
                do_wr(VEC[i].addr, VEC[i].data);
            end else begin
                do_rd(VEC[i].addr, rv);
                check({tag, " rdata"}, {32'h0, rv}, {32'h0, VEC[i].data});
            end
            check({tag, " pad_out"}, pad_out, {VEC[i].o1, VEC[i].o0});
            check({tag, " pad_oe"}, pad_oe, {VEC[i].e1, VEC[i].e0});
        end

        // R12: read data valid for one cycle, then zero while idle
        do_rd(14'h2104, rv);
        check("R12 read port1 data", {32'h0, rv}, {32'h0, 32'h12345677});
        @(negedge clk);
        check("R12 rdata idle", {32'h0, bus_rdata}, 64'h0);

        // R9: strobe read has no side effect on pads
        do_rd(14'h2404, rv);
        check("R9 dclr read zero", {32'h0, rv}, 64'h0);
        check("R9 pad_oe after strobe read", pad_oe, {32'h00000011, 32'h000000AA});

        // R1: reset in mid-run clears everything
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 pad_out after mid reset", pad_out, 64'h0);
        check("R1 pad_oe after mid reset", pad_oe, 64'h0);
        rst_n = 1'b1;
        do_rd(14'h2080, rv);
        check("R1 mask after mid reset", {32'h0, rv}, 64'h0);

        finish_run();
    end

endmodule